// File: doc/BRIEF.md
# External Interrupt Source Arbiter

This block picks the next external-class interrupt to deliver to a processor. When a delivery request arrives and the status-word external mask is set, it checks five sources in a fixed priority order. Each source counts only if it is pending and its own subclass enable bit is set. For the winning source the block reports an interruption code, a processor address and, for service signals, a 32-bit parameter. It also issues the strobes that tell the surrounding logic which pending state to retire.

The emergency-signal source is a 64-bit bitmap with one bit per signalling processor. Each delivery takes only the lowest-numbered processor, clears that one bit, and drops the emergency pending flag only when the bitmap becomes empty. All outputs are registered and qualified by a single-cycle grant pulse. A request that cannot be served raises a single-cycle error pulse instead.

Top module: `ext_irq_arbiter`

## Requirements
- R1: Priority is fixed, highest first: emergency signal (code 0x1201), external call (0x1202), clock comparator (0x1004), processor timer (0x1005), service signal (0x2401); the code of the highest eligible source appears on code_o.
- R2: A source is eligible only when it is pending and its bit in en_i is set (bit 0 emergency, bit 1 external call, bit 2 clock comparator, bit 3 processor timer, bit 4 service); the emergency source also needs a non-empty bitmap; an ineligible source is skipped in favour of the next eligible one.
- R3: An emergency delivery reports the index of the lowest set bit of sig_map_i on cpu_addr_o, and sig_clr_o is one-hot on exactly that bit.
- R4: emerg_clr_o is raised with an emergency delivery only when the bit being cleared was the last set bit of sig_map_i.
- R5: An external-call delivery reports xcall_addr_i on cpu_addr_o and raises xcall_clr_o.
- R6: Clock-comparator and processor-timer deliveries report processor address 0 and raise only their own clear strobe (ckc_clr_o or cpt_clr_o).
- R7: A service delivery raises svc_deq_o, reports svc_param_i on param_o and address 0; for every other source param_o is 0.
- R8: A request while ext_mask_i is low, or while no source is eligible, gives a one-cycle err_o pulse with no grant and no strobes.
- R9: Outputs are registered: a request sampled at one rising edge produces grant_o or err_o for the single following cycle; a request sampled while grant_o or err_o is high is ignored; with no grant, all code, address, parameter and strobe outputs are 0.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Delivery request |
| ext_mask_i | input | 1 | External mask bit of the status word |
| en_i | input | 5 | Subclass enables, one per source |
| emerg_pend_i | input | 1 | Emergency-signal pending flag |
| sig_map_i | input | 64 | Bitmap of signalling processors |
| xcall_pend_i | input | 1 | External-call pending flag |
| xcall_addr_i | input | 16 | Stored caller processor address |
| ckc_pend_i | input | 1 | Clock-comparator pending flag |
| cpt_pend_i | input | 1 | Processor-timer pending flag |
| svc_avail_i | input | 1 | Service queue not empty |
| svc_param_i | input | 32 | Parameter at the head of the service queue |
| grant_o | output | 1 | One-cycle delivery pulse |
| err_o | output | 1 | One-cycle error pulse |
| code_o | output | 16 | Interruption code |
| cpu_addr_o | output | 16 | Reported processor address |
| param_o | output | 32 | Reported service parameter |
| sig_clr_o | output | 64 | One-hot clear of the delivered bitmap bit |
| emerg_clr_o | output | 1 | Clear emergency pending flag |
| xcall_clr_o | output | 1 | Clear external-call pending flag |
| ckc_clr_o | output | 1 | Clear clock-comparator pending flag |
| cpt_clr_o | output | 1 | Clear processor-timer pending flag |
| svc_deq_o | output | 1 | Dequeue one service parameter |

## Verification
On every cycle the assertions check that grant and error never coincide and that a grant lasts one cycle. They also check that a grant retires exactly one source class and that the bitmap clear is one-hot only for emergency deliveries. A request with the mask clear must be followed by an error, and the emergency flag clear must travel with a bitmap clear. The priority order, the effect of each enable bit, lowest-bit draining across several deliveries, and the exact codes, addresses and parameters are shown only by the bench scenarios. Those scenarios compare results against values worked out from the requirements.

// File: rtl/ext_arb_pkg.sv
package ext_arb_pkg;
  localparam int NUM_SRC = 5;
  localparam int MAP_W   = 64;
  localparam int ADDR_W  = 16;
  localparam int PARAM_W = 32;
  localparam int CODE_W  = 16;

  // source index doubles as priority rank (0 = highest)
  localparam int S_EMERG = 0;
  localparam int S_XCALL = 1;
  localparam int S_CKC   = 2;
  localparam int S_CPT   = 3;
  localparam int S_SVC   = 4;

  localparam logic [CODE_W-1:0] CODE_EMERG = 16'h1201;
  localparam logic [CODE_W-1:0] CODE_XCALL = 16'h1202;
  localparam logic [CODE_W-1:0] CODE_CKC   = 16'h1004;
  localparam logic [CODE_W-1:0] CODE_CPT   = 16'h1005;
  localparam logic [CODE_W-1:0] CODE_SVC   = 16'h2401;
endpackage

// File: rtl/ext_lsb_find.sv
module ext_lsb_find #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  map_i,
  output logic [W-1:0]  onehot_o,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);
  assign onehot_o = map_i & (~map_i + W'(1));
  assign found_o  = |map_i;

  // scan downward so the lowest set bit is written last
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (map_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/ext_prio_sel.sv
module ext_prio_sel #(
  parameter int N = 5
) (
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] pick_o,
  output logic         any_o
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_rank
    assign pick_o[k]    = elig_i[k] & ~blocked[k];
    assign blocked[k+1] = blocked[k] | elig_i[k];
  end

  assign any_o = blocked[N];
endmodule

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter
  import ext_arb_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                ext_mask_i,
  input  logic [NUM_SRC-1:0]  en_i,
  input  logic                emerg_pend_i,
  input  logic [MAP_W-1:0]    sig_map_i,
  input  logic                xcall_pend_i,
  input  logic [ADDR_W-1:0]   xcall_addr_i,
  input  logic                ckc_pend_i,
  input  logic                cpt_pend_i,
  input  logic                svc_avail_i,
  input  logic [PARAM_W-1:0]  svc_param_i,
  output logic                grant_o,
  output logic                err_o,
  output logic [CODE_W-1:0]   code_o,
  output logic [ADDR_W-1:0]   cpu_addr_o,
  output logic [PARAM_W-1:0]  param_o,
  output logic [MAP_W-1:0]    sig_clr_o,
  output logic                emerg_clr_o,
  output logic                xcall_clr_o,
  output logic                ckc_clr_o,
  output logic                cpt_clr_o,
  output logic                svc_deq_o
);
  localparam int IDX_W = $clog2(MAP_W);

  logic [MAP_W-1:0]   sig_oh;
  logic [IDX_W-1:0]   sig_idx;
  logic               sig_any;
  logic [NUM_SRC-1:0] elig, pick;
  logic               any_elig;
  logic               accept, do_grant, do_err;

  ext_lsb_find #(.W(MAP_W)) u_lsb (
    .map_i    (sig_map_i),
    .onehot_o (sig_oh),
    .idx_o    (sig_idx),
    .found_o  (sig_any)
  );

  always_comb begin
    elig          = '0;
    elig[S_EMERG] = emerg_pend_i & sig_any & en_i[S_EMERG];
    elig[S_XCALL] = xcall_pend_i & en_i[S_XCALL];
    elig[S_CKC]   = ckc_pend_i   & en_i[S_CKC];
    elig[S_CPT]   = cpt_pend_i   & en_i[S_CPT];
    elig[S_SVC]   = svc_avail_i  & en_i[S_SVC];
  end

  ext_prio_sel #(.N(NUM_SRC)) u_sel (
    .elig_i (elig),
    .pick_o (pick),
    .any_o  (any_elig)
  );

  // one idle cycle between deliveries lets pending state settle
  assign accept   = req_i & ~grant_o & ~err_o;
  assign do_grant = accept & ext_mask_i & any_elig;
  assign do_err   = accept & ~(ext_mask_i & any_elig);

  logic [CODE_W-1:0]  code_d;
  logic [ADDR_W-1:0]  addr_d;
  logic [PARAM_W-1:0] param_d;
  logic               last_sig;

  assign last_sig = (sig_map_i & ~sig_oh) == '0;

  always_comb begin
    code_d  = '0;
    addr_d  = '0;
    param_d = '0;
    unique case (1'b1)
      pick[S_EMERG]: begin code_d = CODE_EMERG; addr_d = ADDR_W'(sig_idx); end
      pick[S_XCALL]: begin code_d = CODE_XCALL; addr_d = xcall_addr_i; end
      pick[S_CKC]:   code_d = CODE_CKC;
      pick[S_CPT]:   code_d = CODE_CPT;
      pick[S_SVC]:   begin code_d = CODE_SVC; param_d = svc_param_i; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o     <= 1'b0;
      err_o       <= 1'b0;
      code_o      <= '0;
      cpu_addr_o  <= '0;
      param_o     <= '0;
      sig_clr_o   <= '0;
      emerg_clr_o <= 1'b0;
      xcall_clr_o <= 1'b0;
      ckc_clr_o   <= 1'b0;
      cpt_clr_o   <= 1'b0;
      svc_deq_o   <= 1'b0;
    end else begin
      grant_o     <= do_grant;
      err_o       <= do_err;
      code_o      <= do_grant ? code_d  : '0;
      cpu_addr_o  <= do_grant ? addr_d  : '0;
      param_o     <= do_grant ? param_d : '0;
      sig_clr_o   <= (do_grant & pick[S_EMERG]) ? sig_oh : '0;
      emerg_clr_o <= do_grant & pick[S_EMERG] & last_sig;
      xcall_clr_o <= do_grant & pick[S_XCALL];
      ckc_clr_o   <= do_grant & pick[S_CKC];
      cpt_clr_o   <= do_grant & pick[S_CPT];
      svc_deq_o   <= do_grant & pick[S_SVC];
    end
  end

  // R9: grant and error exclusive, grant one cycle long
  p_grant_err_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && err_o));
  p_grant_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);
  // R1: a grant retires exactly one source class
  p_one_class_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $countones({|sig_clr_o, xcall_clr_o, ckc_clr_o, cpt_clr_o, svc_deq_o}) == 1);
  // R3: bitmap clear is one-hot and only for emergency deliveries
  p_sig_clr_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_clr_o != '0) |-> ($countones(sig_clr_o) == 1 && grant_o && code_o == CODE_EMERG));
  // R4: flag clear travels with a bitmap clear
  p_emerg_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emerg_clr_o |-> (sig_clr_o != '0));
  // R8: masked request yields error and nothing else
  p_masked_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ext_mask_i && !grant_o && !err_o) |=> (err_o && !grant_o));
  // R7: service parameter only shows with a dequeue
  p_param_svc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (param_o != '0) |-> svc_deq_o);
endmodule

// File: tb/ext_irq_arbiter_test.sv
module ext_irq_arbiter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        ext_mask_i = 1'b0;
  logic [4:0]  en_i = '0;
  logic        emerg_pend_i = 1'b0;
  logic [63:0] sig_map_i = '0;
  logic        xcall_pend_i = 1'b0;
  logic [15:0] xcall_addr_i = '0;
  logic        ckc_pend_i = 1'b0;
  logic        cpt_pend_i = 1'b0;
  logic        svc_avail_i = 1'b0;
  logic [31:0] svc_param_i = '0;
  logic        grant_o, err_o;
  logic [15:0] code_o, cpu_addr_o;
  logic [31:0] param_o;
  logic [63:0] sig_clr_o;
  logic        emerg_clr_o, xcall_clr_o, ckc_clr_o, cpt_clr_o, svc_deq_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  ext_irq_arbiter uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    ext_mask_i = 1'b1; en_i = 5'h1f;
    emerg_pend_i = 0; sig_map_i = '0; xcall_pend_i = 0; xcall_addr_i = '0;
    ckc_pend_i = 0; cpt_pend_i = 0; svc_avail_i = 0; svc_param_i = '0;
  endtask

  // one-cycle request at a negedge; results checked at the next negedge
  task automatic pulse_req();
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk_i);
  endtask

  task automatic expect_grant(input string tag, input logic [15:0] code, input logic [15:0] addr,
                              input logic [31:0] prm);
    chk(grant_o === 1'b1 && err_o === 1'b0, {tag, " grant"}, {grant_o, err_o}, 2'b10);
    chk(code_o === code, {tag, " code"}, code_o, code);
    chk(cpu_addr_o === addr, {tag, " addr"}, cpu_addr_o, addr);
    chk(param_o === prm, {tag, " param"}, param_o, prm);
  endtask

  task automatic t_reset();
    chk({grant_o, err_o, code_o, cpu_addr_o, param_o, emerg_clr_o, xcall_clr_o, ckc_clr_o,
         cpt_clr_o, svc_deq_o} === '0 && sig_clr_o === '0, "R10 reset outputs", code_o, 0);
  endtask

  task automatic t_priority();
    clear_inputs();
    emerg_pend_i = 1; sig_map_i = 64'h10; xcall_pend_i = 1; xcall_addr_i = 16'h33;
    ckc_pend_i = 1; cpt_pend_i = 1; svc_avail_i = 1; svc_param_i = 32'hCAFE0001;
    pulse_req();
    expect_grant("R1 all pending", 16'h1201, 16'd4, 32'h0);
    idle();
    emerg_pend_i = 0; sig_map_i = '0;
    pulse_req();
    expect_grant("R1 xcall next", 16'h1202, 16'h33, 32'h0);
    idle();
    xcall_pend_i = 0;
    pulse_req();
    expect_grant("R1 ckc next", 16'h1004, 16'h0, 32'h0);
    idle();
    ckc_pend_i = 0;
    pulse_req();
    expect_grant("R1 cpt next", 16'h1005, 16'h0, 32'h0);
    idle();
  endtask

  task automatic t_enable_skip();
    clear_inputs();
    emerg_pend_i = 1; sig_map_i = 64'h1; xcall_pend_i = 1; ckc_pend_i = 1; cpt_pend_i = 1;
    en_i = 5'b11000;   // only timer and service enabled
    pulse_req();
    expect_grant("R2 skip disabled", 16'h1005, 16'h0, 32'h0);
    chk(cpt_clr_o && !ckc_clr_o && !xcall_clr_o && sig_clr_o == '0, "R2 strobes", {ckc_clr_o, cpt_clr_o}, 2'b01);
    idle();
    en_i = 5'h1f; emerg_pend_i = 1; sig_map_i = '0;   // pending but empty bitmap
    pulse_req();
    expect_grant("R2 empty bitmap", 16'h1202, 16'h0, 32'h0);
    idle();
  endtask

  task automatic t_emerg_drain();
    clear_inputs();
    emerg_pend_i = 1; sig_map_i = (64'h1 << 5) | (64'h1 << 40) | (64'h1 << 63);
    for (int n = 0; n < 3; n++) begin
      logic [15:0] exp_idx;
      exp_idx = (n == 0) ? 16'd5 : (n == 1) ? 16'd40 : 16'd63;
      pulse_req();
      expect_grant("R3 drain", 16'h1201, exp_idx, 32'h0);
      chk(sig_clr_o === (64'h1 << exp_idx), "R3 one-hot clear", sig_clr_o, 64'h1 << exp_idx);
      chk(emerg_clr_o === (n == 2), "R4 flag clear on last", emerg_clr_o, n == 2);
      sig_map_i = sig_map_i & ~sig_clr_o;
      idle();
    end
  endtask

  task automatic t_xcall();
    clear_inputs();
    xcall_pend_i = 1; xcall_addr_i = 16'hBEEF; svc_avail_i = 1; svc_param_i = 32'h1;
    pulse_req();
    expect_grant("R5 xcall", 16'h1202, 16'hBEEF, 32'h0);
    chk(xcall_clr_o && !svc_deq_o, "R5 xcall clear", {xcall_clr_o, svc_deq_o}, 2'b10);
    idle();
  endtask

  task automatic t_ckc();
    clear_inputs();
    ckc_pend_i = 1; xcall_addr_i = 16'h77;
    pulse_req();
    expect_grant("R6 ckc", 16'h1004, 16'h0, 32'h0);
    chk(ckc_clr_o && !cpt_clr_o, "R6 ckc strobe", {ckc_clr_o, cpt_clr_o}, 2'b10);
    idle();
  endtask

  task automatic t_service();
    clear_inputs();
    svc_avail_i = 1; svc_param_i = 32'hA5A5_1234;
    pulse_req();
    expect_grant("R7 service", 16'h2401, 16'h0, 32'hA5A5_1234);
    chk(svc_deq_o === 1'b1, "R7 dequeue", svc_deq_o, 1);
    idle();
  endtask

  task automatic t_errors();
    clear_inputs();
    ext_mask_i = 0; ckc_pend_i = 1;
    pulse_req();
    chk(err_o && !grant_o && !ckc_clr_o && code_o == 0, "R8 masked", {err_o, grant_o}, 2'b10);
    idle();
    clear_inputs();
    xcall_pend_i = 1; en_i = 5'b11101;
    pulse_req();
    chk(err_o && !grant_o && !xcall_clr_o, "R8 none eligible", {err_o, grant_o}, 2'b10);
    idle();
    chk(!err_o, "R8 error one cycle", err_o, 0);
  endtask

  task automatic t_busy();
    clear_inputs();
    ckc_pend_i = 1; cpt_pend_i = 1;
    req_i = 1;
    @(negedge clk_i);
    expect_grant("R9 first", 16'h1004, 16'h0, 32'h0);
    @(negedge clk_i);   // request held during grant cycle is ignored
    req_i = 0;
    chk(!grant_o && !err_o && code_o == 0 && !cpt_clr_o, "R9 ignored while busy", {grant_o, err_o}, 2'b00);
    idle();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        idle();
        t_reset();
        t_priority();
        t_enable_skip();
        t_emerg_drain();
        t_xcall();
        t_ckc();
        t_service();
        t_errors();
        t_busy();
      end
      begin
        repeat (20000) @(posedge clk_i);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule